// File: doc/BRIEF.md
# Falling-Edge Port Interrupt Controller

This block turns high-to-low transitions on a four-bit general-purpose input port and on an analog comparator's output into interrupt requests for a small CPU. Every port bit and the comparator get a pending flag and an enable. A flag is set by a detected falling edge, whether or not its enable is set. The single external request line to the CPU is high whenever any flag is pending and enabled.

Each input passes through a two-flop synchronizer before edge detection. A port bit can raise an edge only while its direction input marks it as a digital input. A bit that is being used as an analog input stays silent. The CPU reaches the enables and flags through a nibble-wide register port. A write to a flag register clears each bit written as 0 and keeps each bit written as 1. An edge arriving in the same cycle as a clear wins.

Top module: `fedge_irq_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears all enables, all flags and the synchronizer state. In the cycle after a reset edge, `irq_o` is 0 and every register reads 0.
- R2: A pin that is a digital input (`pin_din_i` bit = 1) and changes from 1 to 0 sets its flag. The new flag value is visible after the third rising clock edge that samples the low level.
- R3: A low-to-high transition on any pin or on the comparator output never sets a flag.
- R4: A pin whose `pin_din_i` bit is 0 when its synchronized level falls does not set its flag.
- R5: A flag is set by an edge even when its enable is 0. The enable gates only `irq_o`.
- R6: A write with `reg_sel_i` = 1 (flag register) clears each flag whose `reg_wdata_i` bit is 0 and leaves unchanged each flag whose bit is 1.
- R7: If a falling edge is detected on a bit in the same cycle that a write clears that bit, the flag ends up set.
- R8: `irq_o` equals the OR over the four port bits of (flag AND enable), ORed with (comparator flag AND comparator enable). It is combinational from the registers.
- R9: A falling edge of `cmp_i` sets the comparator flag through the same synchronizer and detector path as the port pins (same latency). It does not depend on `pin_din_i`.
- R10: Register map, selected by `reg_sel_i`. Select 0 is the port enables (bit n = pin n) and is written directly. Select 1 is the port flags. Select 2 holds the comparator enable in bit 0 (written directly) and the comparator flag in bit 1 (cleared by writing 0); its bits 3:2 read 0. Select 3 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 4 | Asynchronous port pin levels |
| pin_din_i | input | 4 | Per-bit direction: 1 = digital input, 0 = analog/other |
| cmp_i | input | 1 | Asynchronous comparator output |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 4 | Register write data |
| reg_rdata_o | output | 4 | Register read data for `reg_sel_i` (combinational) |
| irq_o | output | 1 | External interrupt request |

## Verification
The bench targets the cases where a flag must not change. The first is rising edges: a design that detected either edge would set flags there. The second is a pin marked analog when it falls: a design that ignored direction would interrupt on analog pins. The third is writes of 1 to the flag register: a write-1-to-clear design would drop those flags.

It holds a flag-clear write across the exact cycle in which an edge is detected. A design that let the clear win would lose that interrupt. It also checks latency to the cycle, so a missing or extra synchronizer stage shows up as a miscompare. Finally, edges with enables at 0 must leave flags set with `irq_o` low. A design that gated the flag rather than the request would show nothing pending.

// File: rtl/fedge_irq_pkg.sv
package fedge_irq_pkg;
  localparam int REG_W = 4;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_FLAGS  = 2'd1,
    SEL_CMP    = 2'd2,
    SEL_VOID   = 2'd3
  } reg_sel_e;

  // Bit positions inside the comparator control nibble.
  localparam int CMP_EN_BIT   = 0;
  localparam int CMP_FLAG_BIT = 1;

  // Flag update: write-0-clears under a write strobe, edge set dominates.
  function automatic logic flag_next(input logic cur, input logic wr,
                                     input logic keep, input logic set);
    logic kept;
    kept = wr ? (cur & keep) : cur;
    return kept | set;
  endfunction

  // Falling edge seen between two consecutive synchronized samples.
  function automatic logic is_fall(input logic older, input logic newer);
    return older & ~newer;
  endfunction
endpackage

// File: rtl/fedge_sync.sv
module fedge_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stage1_q, stage2_q, stage3_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1_q[i] <= 1'b0;
        stage2_q[i] <= 1'b0;
        stage3_q[i] <= 1'b0;
      end else begin
        stage1_q[i] <= async_i[i];
        stage2_q[i] <= stage1_q[i];
        stage3_q[i] <= stage2_q[i];
      end
    end
  end

  assign sync_o = stage2_q;
  assign prev_o = stage3_q;
endmodule

// File: rtl/fedge_fall_det.sv
module fedge_fall_det
  import fedge_irq_pkg::*;
#(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] fall_o
);
  for (genvar i = 0; i < W; i++) begin : g_det
    assign fall_o[i] = is_fall(prev_i[i], sync_i[i]) & din_i[i];

    // R4: a bit not marked as a digital input never reports an edge
    p_analog_quiet_r4 : assert property (@(posedge clk) disable iff (rst)
      !din_i[i] |-> !fall_o[i]);
    // R3: a rising or steady level is never reported as an edge
    p_no_rise_edge_r3 : assert property (@(posedge clk) disable iff (rst)
      sync_i[i] |-> !fall_o[i]);
  end
endmodule

// File: rtl/fedge_flag_bank.sv
module fedge_flag_bank
  import fedge_irq_pkg::*;
#(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS:0]   fall_i,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [NPINS-1:0] en_o,
  output logic [NPINS-1:0] flag_o,
  output logic             cmp_en_o,
  output logic             cmp_flag_o
);
  localparam int CMP_IDX = NPINS;

  logic [NPINS-1:0] en_q, flag_q;
  logic             cmp_en_q, cmp_flag_q;
  logic             wr_en, wr_flag, wr_cmp;

  assign wr_en   = we_i && (sel_i == SEL_ENABLE);
  assign wr_flag = we_i && (sel_i == SEL_FLAGS);
  assign wr_cmp  = we_i && (sel_i == SEL_CMP);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[i]   <= 1'b0;
        flag_q[i] <= 1'b0;
      end else begin
        if (wr_en) en_q[i] <= wdata_i[i];
        flag_q[i] <= flag_next(flag_q[i], wr_flag, wdata_i[i], fall_i[i]);
      end
    end

    // R2/R5: a detected edge sets the flag whatever the enable holds
    p_edge_sets_r2 : assert property (@(posedge clk) disable iff (rst)
      fall_i[i] |=> flag_q[i]);
    // R3/R6: without an edge a clear flag stays clear
    p_no_spurious_r3 : assert property (@(posedge clk) disable iff (rst)
      (!flag_q[i] && !fall_i[i]) |=> !flag_q[i]);
    // R7: edge wins over a simultaneous clear
    p_set_beats_clear_r7 : assert property (@(posedge clk) disable iff (rst)
      (fall_i[i] && wr_flag && !wdata_i[i]) |=> flag_q[i]);
    // R6: writing 1 keeps a pending flag
    p_write_one_keeps_r6 : assert property (@(posedge clk) disable iff (rst)
      (flag_q[i] && wr_flag && wdata_i[i]) |=> flag_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_en_q   <= 1'b0;
      cmp_flag_q <= 1'b0;
    end else begin
      if (wr_cmp) cmp_en_q <= wdata_i[CMP_EN_BIT];
      cmp_flag_q <= flag_next(cmp_flag_q, wr_cmp, wdata_i[CMP_FLAG_BIT],
                              fall_i[CMP_IDX]);
    end
  end

  // R9: comparator edge sets its flag
  p_cmp_edge_sets_r9 : assert property (@(posedge clk) disable iff (rst)
    fall_i[CMP_IDX] |=> cmp_flag_q);
  // R1: state is clear straight after reset
  p_reset_clears_r1 : assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flag_q == '0 && en_q == '0 && !cmp_en_q && !cmp_flag_q));

  assign en_o       = en_q;
  assign flag_o     = flag_q;
  assign cmp_en_o   = cmp_en_q;
  assign cmp_flag_o = cmp_flag_q;
endmodule

// File: rtl/fedge_irq_ctrl.sv
module fedge_irq_ctrl
  import fedge_irq_pkg::*;
#(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] pin_din_i,
  input  logic             cmp_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o
);
  localparam int NSRC = NPINS + 1;

  logic [NSRC-1:0]  src_async, src_sync, src_prev, src_din, src_fall;
  logic [NPINS-1:0] en, flag;
  logic             cmp_en, cmp_flag;
  logic             port_req, cmp_req;

  assign src_async = {cmp_i, pin_i};
  assign src_din   = {1'b1, pin_din_i};

  fedge_sync #(.W(NSRC)) u_sync (
    .clk(clk), .rst(rst), .async_i(src_async),
    .sync_o(src_sync), .prev_o(src_prev)
  );

  fedge_fall_det #(.W(NSRC)) u_det (
    .clk(clk), .rst(rst), .sync_i(src_sync), .prev_i(src_prev),
    .din_i(src_din), .fall_o(src_fall)
  );

  fedge_flag_bank #(.NPINS(NPINS)) u_bank (
    .clk(clk), .rst(rst), .fall_i(src_fall),
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .en_o(en), .flag_o(flag), .cmp_en_o(cmp_en), .cmp_flag_o(cmp_flag)
  );

  assign port_req = |(flag & en);
  assign cmp_req  = cmp_flag & cmp_en;
  assign irq_o    = port_req | cmp_req;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_sel_i)
      SEL_ENABLE: reg_rdata_o[NPINS-1:0] = en;
      SEL_FLAGS:  reg_rdata_o[NPINS-1:0] = flag;
      SEL_CMP: begin
        reg_rdata_o[CMP_EN_BIT]   = cmp_en;
        reg_rdata_o[CMP_FLAG_BIT] = cmp_flag;
      end
      default:    reg_rdata_o = '0;
    endcase
  end

  // R8: with every enable off the request stays low
  p_irq_masked_r8 : assert property (@(posedge clk) disable iff (rst)
    (en == '0 && !cmp_en) |-> !irq_o);
  // R8: with no flag pending the request stays low
  p_irq_needs_flag_r8 : assert property (@(posedge clk) disable iff (rst)
    (flag == '0 && !cmp_flag) |-> !irq_o);
endmodule

// File: tb/fedge_irq_ctrl_tb.sv
`timescale 1ns/1ps
module fedge_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] pin_i, pin_din_i;
  logic       cmp_i, reg_we_i;
  logic [1:0] reg_sel_i;
  logic [3:0] reg_wdata_i, reg_rdata_o;
  logic       irq_o;

  always #2.5 clk = ~clk;

  fedge_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .pin_i(pin_i), .pin_din_i(pin_din_i), .cmp_i(cmp_i),
    .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  int    n_vec = 0, n_bad = 0;
  string cur_req = "R1";
  bit    started = 0, done = 0;

  // Reference model: queues of past samples for each source (index 4 = comparator)
  int m_hist[5][$];
  int m_en[4], m_flag[4];
  int m_cen, m_cflag;

  function automatic int exp_rdata();
    int v = 0;
    case (reg_sel_i)
      2'd0: for (int i = 0; i < 4; i++) v += m_en[i] << i;
      2'd1: for (int i = 0; i < 4; i++) v += m_flag[i] << i;
      2'd2: v = m_cen + 2 * m_cflag;
      default: v = 0;
    endcase
    return v;
  endfunction

  function automatic int exp_irq();
    int r = 0;
    for (int i = 0; i < 4; i++) if (m_flag[i] == 1 && m_en[i] == 1) r = 1;
    if (m_cflag == 1 && m_cen == 1) r = 1;
    return r;
  endfunction

  task automatic model_step();
    int fell[5];
    int lvl;
    if (rst) begin
      for (int s = 0; s < 5; s++) begin
        m_hist[s].delete();
        for (int k = 0; k < 3; k++) m_hist[s].push_back(0);
      end
      for (int i = 0; i < 4; i++) begin m_en[i] = 0; m_flag[i] = 0; end
      m_cen = 0; m_cflag = 0;
      return;
    end
    // The edge is judged on the level seen 3 and 2 edges back
    for (int s = 0; s < 5; s++)
      fell[s] = (m_hist[s][0] == 1 && m_hist[s][1] == 0) ? 1 : 0;
    for (int i = 0; i < 4; i++) if (pin_din_i[i] !== 1'b1) fell[i] = 0;
    if (reg_we_i) begin
      case (reg_sel_i)
        2'd0: for (int i = 0; i < 4; i++) m_en[i] = reg_wdata_i[i];
        2'd1: for (int i = 0; i < 4; i++) if (!reg_wdata_i[i]) m_flag[i] = 0;
        2'd2: begin
          m_cen = reg_wdata_i[0];
          if (!reg_wdata_i[1]) m_cflag = 0;
        end
        default: ;
      endcase
    end
    for (int i = 0; i < 4; i++) if (fell[i] == 1) m_flag[i] = 1;
    if (fell[4] == 1) m_cflag = 1;
    for (int s = 0; s < 5; s++) begin
      lvl = (s < 4) ? int'(pin_i[s]) : int'(cmp_i);
      void'(m_hist[s].pop_front());
      m_hist[s].push_back(lvl);
    end
  endtask

  always @(posedge clk) begin
    model_step();
    started = 1;
    #1;
    if (started && !done) begin
      n_vec++;
      if (int'(reg_rdata_o) != exp_rdata()) begin
        n_bad++;
        $display("FAIL %s: rdata sel=%0d got %0d expected %0d", cur_req,
                 reg_sel_i, reg_rdata_o, exp_rdata());
      end
      n_vec++;
      if (int'(irq_o) != exp_irq()) begin
        n_bad++;
        $display("FAIL %s: irq got %0d expected %0d", cur_req, irq_o, exp_irq());
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] sel, logic [3:0] d);
    @(negedge clk);
    reg_we_i = 1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 0; reg_sel_i = 2'd1;
  endtask

  task automatic chk(string req, int got, int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  initial begin
    rst = 1; pin_i = 4'hF; pin_din_i = 4'hF; cmp_i = 1;
    reg_we_i = 0; reg_sel_i = 2'd1; reg_wdata_i = 0;
    cur_req = "R1"; cyc(3);
    chk("R1", int'(reg_rdata_o), 0);
    chk("R1", int'(irq_o), 0);
    rst = 0; cyc(5);

    // R2/R5: fall on pin 0 with enable off -> flag set, irq low
    cur_req = "R2"; pin_i[0] = 0; cyc(2);
    chk("R2", int'(reg_rdata_o[0]), 0); cyc(1);
    chk("R2", int'(reg_rdata_o[0]), 1);
    chk("R5", int'(irq_o), 0); cyc(3);

    // R3: rise on pin 0 after clearing leaves it clear
    cur_req = "R6"; wr(2'd1, 4'hE); chk("R6", int'(reg_rdata_o), 0);
    cur_req = "R3"; pin_i[0] = 1; cyc(6);
    chk("R3", int'(reg_rdata_o), 0);

    // R4: pin 1 marked analog while it falls
    cur_req = "R4"; pin_din_i[1] = 0; pin_i[1] = 0; cyc(6);
    chk("R4", int'(reg_rdata_o[1]), 0);
    pin_din_i[1] = 1; pin_i[1] = 1; cyc(4);

    // R6: writing 1 keeps pending flags
    cur_req = "R6"; pin_i[2] = 0; pin_i[3] = 0; cyc(5);
    wr(2'd1, 4'hF); chk("R6", int'(reg_rdata_o), 4'hC);
    wr(2'd1, 4'h7); chk("R6", int'(reg_rdata_o), 4'h4);

    // R8: enable 2 raises irq, enable 3 alone does not
    cur_req = "R8"; wr(2'd0, 4'h8); chk("R8", int'(irq_o), 0);
    wr(2'd0, 4'h4); chk("R8", int'(irq_o), 1);
    wr(2'd1, 4'h0); chk("R8", int'(irq_o), 0);
    pin_i = 4'hF; cyc(5);

    // R7: clear held across the cycle the edge of pin 3 is detected
    cur_req = "R7";
    @(negedge clk); pin_i[3] = 0;
    reg_we_i = 1; reg_sel_i = 2'd1; reg_wdata_i = 4'h0;
    cyc(3);
    chk("R7", int'(reg_rdata_o[3]), 1);
    reg_we_i = 0; cyc(1);
    chk("R7", int'(reg_rdata_o[3]), 1);
    wr(2'd1, 4'h0); pin_i[3] = 1; cyc(4);

    // R9: comparator fall, enabled through select 2
    cur_req = "R9"; wr(2'd2, 4'h1);
    reg_sel_i = 2'd2; cmp_i = 0; pin_din_i = 4'h0; cyc(4);
    chk("R9", int'(reg_rdata_o), 3);
    chk("R9", int'(irq_o), 1);
    wr(2'd2, 4'h1); reg_sel_i = 2'd2; chk("R9", int'(irq_o), 0);
    pin_din_i = 4'hF; cmp_i = 1; cyc(4);

    // R10: select 3 reads zero and its writes change nothing
    cur_req = "R10"; wr(2'd0, 4'hA); wr(2'd3, 4'h0);
    reg_sel_i = 2'd3; cyc(1); chk("R10", int'(reg_rdata_o), 0);
    reg_sel_i = 2'd0; cyc(1); chk("R10", int'(reg_rdata_o), 4'hA);

    // Mixed traffic compared against the model every cycle
    cur_req = "R8";
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      pin_i = 4'($urandom); cmp_i = 1'($urandom);
      pin_din_i = 4'($urandom | 32'h9);
      reg_we_i = (($urandom % 5) == 0);
      reg_sel_i = 2'($urandom); reg_wdata_i = 4'($urandom);
    end
    reg_we_i = 0;

    // R1: reset in mid-run clears everything
    cur_req = "R1"; rst = 1; cyc(2); rst = 0; reg_sel_i = 2'd0;
    chk("R1", int'(reg_rdata_o), 0);
    cyc(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule